// File: doc/BRIEF.md
# Remote Terminal Built-In-Test Word

This block keeps the 16-bit self-test status word of a dual-redundant serial-bus remote terminal. Error detectors elsewhere in the terminal report single-cycle pulses: transmitter timeout, loop-back mismatch, late subsystem acknowledge, illegal broadcast and word-count faults. The command decoder presents each decoded command word for one cycle as a valid strobe with a mode flag, a 5-bit mode code, the transmit/receive bit and the bus it arrived on. Each bit of the word is set and cleared by its own rule. Status-query mode commands do not disturb the word.

The block also runs a few mode-command side effects that are visible in the word. These are the terminal-flag inhibit state, the per-bus shutdown state and an armed self-test whose outcome can raise the timeout bit. When a legal transmit-BIT-word command arrives, the word is frozen into a separate snapshot output. The serialiser then sends a value that stays stable while new errors keep landing in the live word.

Top module: `rt_bit_word`

## Requirements
- R1: After the asynchronous active-low reset, `bit_word` and `tbw_word` are both 0 and no self-test is armed.
- R2: Bits 15, 14 and 10 of `bit_word` read 0 at all times.
- R3: A legal mode command with code 8 (T/R=1, subsystem illegal input high) clears every bit and disarms the self-test on the next edge. It overrides any event pulse in the same cycle.
- R4: Legal mode commands with codes 2, 18 and 19 (T/R=1) leave bits 3, 4, 8, 9 and 11 unchanged.
- R5: An `ev_tx_timeout` pulse sets bit 0. It also sets bit 13 when `tx_bus` is 1, or bit 12 when `tx_bus` is 0.
- R6: A legal mode command with code 3 (T/R=1) arms a self-test. A `st_result_valid` pulse disarms it, and if the test was armed before that cycle and `st_result_ok` is 0, bit 0 is set. A result that arrives while nothing is armed has no effect.
- R7: Event pulses set sticky bits: loop failure sets bit 2, handshake failure sets bit 1, illegal broadcast sets bit 7, word count high sets bit 6 and word count low sets bit 5. Only R1 and R3 clear these bits.
- R8: Bit 3 is set by a valid mode command whose T/R bit is wrong. T/R must be 1 for codes 0–16, 18 and 19, and 0 for codes 17, 20 and 21. Codes 22–31 accept either value.
- R9: Bit 4 is set by a valid command in any of three cases: `ss_illegal_n` is 0; it is a mode command with a reserved code (9–15 or 22–31) while `ss_allow_code` is 1; or it is a mode command with code 20 or 21 (selected-transmitter shutdown, illegal here).
- R10: Any valid command other than an R4 query clears bits 3 and 4. When the same command also sets one of these bits, the set wins.
- R11: A legal code 6 sets bit 11 and a legal code 7 clears it. A legal code 4 shuts down the other bus: it sets bit 9 when `cmd_bus` is 0, or bit 8 when `cmd_bus` is 1. A legal code 5 clears bits 9 and 8.
- R12: A legal code 19 loads `tbw_word` with the value `bit_word` held before that edge. At all other times `tbw_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command word |
| cmd_mode | input | 1 | Command is a mode command |
| cmd_code | input | 5 | Mode code |
| cmd_tr | input | 1 | Transmit/receive bit, 1 = transmit |
| cmd_bus | input | 1 | Bus the command arrived on |
| ss_illegal_n | input | 1 | Subsystem flags command illegal when low |
| ss_allow_code | input | 1 | Subsystem treats reserved mode codes as illegal when high |
| ev_tx_timeout | input | 1 | Transmitter timeout pulse |
| tx_bus | input | 1 | Bus being driven when the timeout occurred |
| ev_loop_fail | input | 1 | Loop-back check failure pulse |
| ev_hs_fail | input | 1 | Subsystem handshake too late pulse |
| ev_bcast_ill | input | 1 | Illegal broadcast pulse |
| ev_wc_high | input | 1 | Too many data words pulse |
| ev_wc_low | input | 1 | Too few data words pulse |
| st_result_valid | input | 1 | Self-test timeout measurement finished |
| st_result_ok | input | 1 | Measured timeout was inside its window |
| bit_word | output | 16 | Live status word |
| tbw_word | output | 16 | Snapshot for the transmit-BIT-word reply |

## Verification
A wrong bit in the live word shows on `bit_word` one edge after the command or pulse that caused it. It stays there, because most bits are sticky, so a single mistake keeps being reported until a reset command. A wrong armed self-test state is hidden until a result pulse arrives, and then shows as bit 0. A wrong capture shows on `tbw_word` only after the next transmit-BIT-word command, or as drift of `tbw_word` between such commands. The bench compares both outputs against its model after every edge.

// File: rtl/rtbw_pkg.sv
package rtbw_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 5;

    localparam int B_TMO      = 0;
    localparam int B_HSK      = 1;
    localparam int B_LOOP     = 2;
    localparam int B_TRBAD    = 3;
    localparam int B_ILLCMD   = 4;
    localparam int B_WCLO     = 5;
    localparam int B_WCHI     = 6;
    localparam int B_BCAST    = 7;
    localparam int B_SHUT0    = 8;
    localparam int B_SHUT1    = 9;
    localparam int B_INHIB    = 11;
    localparam int B_TMO_B0   = 12;
    localparam int B_TMO_B1   = 13;

    localparam logic [WORD_W-1:0] ZERO_MASK  = 16'hC400;
    localparam logic [WORD_W-1:0] QUERY_MASK = 16'h0B18;

    localparam logic [CODE_W-1:0] MC_STATUS   = 5'd2;
    localparam logic [CODE_W-1:0] MC_SELFTEST = 5'd3;
    localparam logic [CODE_W-1:0] MC_SHUT     = 5'd4;
    localparam logic [CODE_W-1:0] MC_OVR_SHUT = 5'd5;
    localparam logic [CODE_W-1:0] MC_INHIB    = 5'd6;
    localparam logic [CODE_W-1:0] MC_OVR_INH  = 5'd7;
    localparam logic [CODE_W-1:0] MC_RTRESET  = 5'd8;
    localparam logic [CODE_W-1:0] MC_RSV1_LO  = 5'd9;
    localparam logic [CODE_W-1:0] MC_RSV1_HI  = 5'd15;
    localparam logic [CODE_W-1:0] MC_TR_LAST  = 5'd16;
    localparam logic [CODE_W-1:0] MC_SYNC_RX  = 5'd17;
    localparam logic [CODE_W-1:0] MC_LASTCMD  = 5'd18;
    localparam logic [CODE_W-1:0] MC_BITWORD  = 5'd19;
    localparam logic [CODE_W-1:0] MC_SEL_SH   = 5'd20;
    localparam logic [CODE_W-1:0] MC_SEL_OVR  = 5'd21;
    localparam logic [CODE_W-1:0] MC_RSV2_LO  = 5'd22;

    typedef struct packed {
        logic legal;
        logic query;
        logic capture;
        logic rt_reset;
        logic self_test;
        logic inhib_on;
        logic inhib_off;
        logic shut;
        logic shut_off;
        logic tr_bad;
        logic illegal;
        logic clr_err;
    } cmd_class_t;

    typedef struct packed {
        logic tx_timeout;
        logic tx_bus;
        logic loop_fail;
        logic hs_fail;
        logic bcast_ill;
        logic wc_high;
        logic wc_low;
        logic st_valid;
        logic st_ok;
        logic cmd_bus;
    } event_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              armed;
    } bit_state_t;
endpackage

// File: rtl/rtbw_decode.sv
module rtbw_decode
    import rtbw_pkg::*;
(
    input  logic              cmd_valid,
    input  logic              cmd_mode,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              cmd_tr,
    input  logic              ss_illegal_n,
    input  logic              ss_allow_code,
    output cmd_class_t        cls
);
    logic reserved;
    logic sel_shut;
    logic tr_checked;
    logic tr_need;
    logic tr_wrong;

    always_comb begin
        reserved = ((cmd_code >= MC_RSV1_LO) && (cmd_code <= MC_RSV1_HI))
                 || (cmd_code >= MC_RSV2_LO);
        sel_shut = (cmd_code == MC_SEL_SH) || (cmd_code == MC_SEL_OVR);

        tr_checked = 1'b1;
        tr_need    = 1'b1;
        if (cmd_code <= MC_TR_LAST) begin
            tr_need = 1'b1;
        end else if ((cmd_code == MC_LASTCMD) || (cmd_code == MC_BITWORD)) begin
            tr_need = 1'b1;
        end else if ((cmd_code == MC_SYNC_RX) || sel_shut) begin
            tr_need = 1'b0;
        end else begin
            tr_checked = 1'b0;
        end
        tr_wrong = cmd_mode && tr_checked && (cmd_tr != tr_need);

        cls.legal     = cmd_valid && cmd_mode && !tr_wrong && ss_illegal_n
                      && !reserved && !sel_shut;
        cls.query     = cls.legal && ((cmd_code == MC_STATUS)
                      || (cmd_code == MC_LASTCMD) || (cmd_code == MC_BITWORD));
        cls.capture   = cls.legal && (cmd_code == MC_BITWORD);
        cls.rt_reset  = cls.legal && (cmd_code == MC_RTRESET);
        cls.self_test = cls.legal && (cmd_code == MC_SELFTEST);
        cls.inhib_on  = cls.legal && (cmd_code == MC_INHIB);
        cls.inhib_off = cls.legal && (cmd_code == MC_OVR_INH);
        cls.shut      = cls.legal && (cmd_code == MC_SHUT);
        cls.shut_off  = cls.legal && (cmd_code == MC_OVR_SHUT);
        cls.tr_bad    = cmd_valid && tr_wrong;
        cls.illegal   = cmd_valid && (!ss_illegal_n
                      || (cmd_mode && reserved && ss_allow_code)
                      || (cmd_mode && sel_shut));
        cls.clr_err   = cmd_valid && !cls.query;
    end
endmodule

// File: rtl/rtbw_update.sv
module rtbw_update
    import rtbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_class_t        cls,
    input  event_t            ev,
    output logic [WORD_W-1:0] word_o
);
    bit_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cls.rt_reset) begin
            st_d.word  = '0;
            st_d.armed = 1'b0;
        end else begin
            // self-test outcome uses the arm state from before this edge
            if (ev.st_valid) begin
                st_d.armed = 1'b0;
                if (st_q.armed && !ev.st_ok) st_d.word[B_TMO] = 1'b1;
            end
            if (cls.self_test) st_d.armed = 1'b1;

            // clears first, sets afterwards so a set wins
            if (cls.clr_err) begin
                st_d.word[B_TRBAD]  = 1'b0;
                st_d.word[B_ILLCMD] = 1'b0;
            end
            if (cls.inhib_off) st_d.word[B_INHIB] = 1'b0;
            if (cls.shut_off) begin
                st_d.word[B_SHUT0] = 1'b0;
                st_d.word[B_SHUT1] = 1'b0;
            end

            if (cls.inhib_on) st_d.word[B_INHIB] = 1'b1;
            if (cls.shut) begin
                if (ev.cmd_bus) st_d.word[B_SHUT0] = 1'b1;
                else            st_d.word[B_SHUT1] = 1'b1;
            end
            if (cls.tr_bad)  st_d.word[B_TRBAD]  = 1'b1;
            if (cls.illegal) st_d.word[B_ILLCMD] = 1'b1;
            if (ev.tx_timeout) begin
                st_d.word[B_TMO] = 1'b1;
                if (ev.tx_bus) st_d.word[B_TMO_B1] = 1'b1;
                else           st_d.word[B_TMO_B0] = 1'b1;
            end
            if (ev.loop_fail) st_d.word[B_LOOP]  = 1'b1;
            if (ev.hs_fail)   st_d.word[B_HSK]   = 1'b1;
            if (ev.bcast_ill) st_d.word[B_BCAST] = 1'b1;
            if (ev.wc_high)   st_d.word[B_WCHI]  = 1'b1;
            if (ev.wc_low)    st_d.word[B_WCLO]  = 1'b1;
        end
        st_d.word = st_d.word & ~ZERO_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;

    assert_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.word & ZERO_MASK) == '0);

    assert_rtreset_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cls.rt_reset |=> (st_q.word == '0) && !st_q.armed);

    assert_query_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cls.query |=> ((st_q.word & QUERY_MASK) == ($past(st_q.word) & QUERY_MASK)));

    assert_timeout_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.tx_timeout && !cls.rt_reset) |=> st_q.word[B_TMO]);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cls.tr_bad && !cls.rt_reset) |=> st_q.word[B_TRBAD]);

    assert_unarmed_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.st_valid && !st_q.armed && !ev.tx_timeout && !cls.rt_reset)
        |=> st_q.word[B_TMO] == $past(st_q.word[B_TMO]));
endmodule

// File: rtl/rtbw_snap.sv
module rtbw_snap
    import rtbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] live,
    output logic [WORD_W-1:0] snap_o
);
    logic [WORD_W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (capture) snap_d = live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign snap_o = snap_q;

    assert_snap_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap_q));

    assert_snap_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> snap_q == $past(live));
endmodule

// File: rtl/rt_bit_word.sv
module rt_bit_word
    import rtbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_mode,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              cmd_tr,
    input  logic              cmd_bus,
    input  logic              ss_illegal_n,
    input  logic              ss_allow_code,
    input  logic              ev_tx_timeout,
    input  logic              tx_bus,
    input  logic              ev_loop_fail,
    input  logic              ev_hs_fail,
    input  logic              ev_bcast_ill,
    input  logic              ev_wc_high,
    input  logic              ev_wc_low,
    input  logic              st_result_valid,
    input  logic              st_result_ok,
    output logic [WORD_W-1:0] bit_word,
    output logic [WORD_W-1:0] tbw_word
);
    cmd_class_t cls;
    event_t     ev;

    always_comb begin
        ev.tx_timeout = ev_tx_timeout;
        ev.tx_bus     = tx_bus;
        ev.loop_fail  = ev_loop_fail;
        ev.hs_fail    = ev_hs_fail;
        ev.bcast_ill  = ev_bcast_ill;
        ev.wc_high    = ev_wc_high;
        ev.wc_low     = ev_wc_low;
        ev.st_valid   = st_result_valid;
        ev.st_ok      = st_result_ok;
        ev.cmd_bus    = cmd_bus;
    end

    rtbw_decode u_decode (
        .cmd_valid     (cmd_valid),
        .cmd_mode      (cmd_mode),
        .cmd_code      (cmd_code),
        .cmd_tr        (cmd_tr),
        .ss_illegal_n  (ss_illegal_n),
        .ss_allow_code (ss_allow_code),
        .cls           (cls)
    );

    rtbw_update u_update (
        .clk    (clk),
        .rst_n  (rst_n),
        .cls    (cls),
        .ev     (ev),
        .word_o (bit_word)
    );

    rtbw_snap u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cls.capture),
        .live    (bit_word),
        .snap_o  (tbw_word)
    );
endmodule

// File: tb/rt_bit_word_tb.sv
`timescale 1ns/1ps
module rt_bit_word_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid, cmd_mode, cmd_tr, cmd_bus, ss_illegal_n, ss_allow_code;
    logic [4:0] cmd_code;
    logic ev_tx_timeout, tx_bus, ev_loop_fail, ev_hs_fail, ev_bcast_ill;
    logic ev_wc_high, ev_wc_low, st_result_valid, st_result_ok;
    logic [15:0] bit_word, tbw_word;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_word = '0;
    logic [15:0] m_snap = '0;
    logic        m_arm  = 1'b0;

    always #2.5 clk = ~clk;

    rt_bit_word u_dut (.*);

    task automatic chk(input logic [15:0] got, input logic [15:0] exp,
                       input logic [15:0] mask, input string tag);
        n_chk++;
        if ((got & mask) !== (exp & mask)) begin
            n_bad++;
            $display("FAIL %s: got %04h expected %04h (mask %04h) at %0t",
                     tag, got & mask, exp & mask, mask, $time);
        end
    endtask

    task automatic idle();
        cmd_valid = 0; cmd_mode = 0; cmd_code = 0; cmd_tr = 0; cmd_bus = 0;
        ss_illegal_n = 1; ss_allow_code = 0;
        ev_tx_timeout = 0; tx_bus = 0; ev_loop_fail = 0; ev_hs_fail = 0;
        ev_bcast_ill = 0; ev_wc_high = 0; ev_wc_low = 0;
        st_result_valid = 0; st_result_ok = 0;
    endtask

    // required T/R per mode code: 1, 0, or -1 for don't care
    function automatic int tr_rule(input int c);
        if (c <= 16 || c == 18 || c == 19) return 1;
        if (c == 17 || c == 20 || c == 21) return 0;
        return -1;
    endfunction

    task automatic model_step();
        int c;
        bit rsv, sel, trbad, legal, qry, illc;
        logic [15:0] nw;
        logic na;
        c = int'(cmd_code);
        rsv   = (c >= 9 && c <= 15) || c >= 22;
        sel   = (c == 20 || c == 21);
        trbad = cmd_mode && tr_rule(c) >= 0 && (int'(cmd_tr) != tr_rule(c));
        legal = cmd_valid && cmd_mode && !trbad && ss_illegal_n && !rsv && !sel;
        qry   = legal && (c == 2 || c == 18 || c == 19);
        illc  = cmd_valid && (!ss_illegal_n || (cmd_mode && rsv && ss_allow_code)
                || (cmd_mode && sel));
        if (legal && c == 19) m_snap = m_word;
        if (legal && c == 8) begin
            nw = '0; na = 0;
        end else begin
            nw = m_word; na = m_arm;
            if (st_result_valid) begin
                na = 0;
                if (m_arm && !st_result_ok) nw[0] = 1;
            end
            if (legal && c == 3) na = 1;
            if (cmd_valid && !qry) begin nw[3] = 0; nw[4] = 0; end
            if (legal && c == 7) nw[11] = 0;
            if (legal && c == 5) begin nw[8] = 0; nw[9] = 0; end
            if (legal && c == 6) nw[11] = 1;
            if (legal && c == 4) begin
                if (cmd_bus) nw[8] = 1; else nw[9] = 1;
            end
            if (cmd_valid && trbad) nw[3] = 1;
            if (illc) nw[4] = 1;
            if (ev_tx_timeout) begin
                nw[0] = 1;
                if (tx_bus) nw[13] = 1; else nw[12] = 1;
            end
            if (ev_loop_fail) nw[2] = 1;
            if (ev_hs_fail)   nw[1] = 1;
            if (ev_bcast_ill) nw[7] = 1;
            if (ev_wc_high)   nw[6] = 1;
            if (ev_wc_low)    nw[5] = 1;
        end
        m_word = nw;
        m_arm  = na;
    endtask

    // inputs are already set; compute model, wait an edge, compare
    task automatic tick();
        model_step();
        @(negedge clk);
        chk(bit_word, m_word, 16'hC400, "R2");
        chk(bit_word, m_word, 16'h3001, "R5 R6");
        chk(bit_word, m_word, 16'h00E6, "R7");
        chk(bit_word, m_word, 16'h0008, "R8 R10 R4");
        chk(bit_word, m_word, 16'h0010, "R9 R10 R4");
        chk(bit_word, m_word, 16'h0B00, "R11 R4");
        chk(tbw_word, m_snap, 16'hFFFF, "R12");
        idle();
    endtask

    task automatic mode_cmd(input int c, input bit tr, input bit bus);
        cmd_valid = 1; cmd_mode = 1; cmd_code = 5'(c); cmd_tr = tr; cmd_bus = bus;
    endtask

    function automatic int pick_code();
        int tab[12] = '{2, 3, 4, 5, 6, 7, 8, 17, 18, 19, 20, 21};
        if ($urandom % 2) return tab[$urandom % 12];
        return int'($urandom % 32);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle();
        @(negedge clk);
        m_word = '0; m_snap = '0; m_arm = 0;
        chk(bit_word, 16'h0000, 16'hFFFF, "R1");
        chk(tbw_word, 16'h0000, 16'hFFFF, "R1");
        rst_n = 1;
    endtask

    initial begin
        void'($urandom(32'd1553));
        idle();
        repeat (3) @(negedge clk);
        chk(bit_word, 16'h0000, 16'hFFFF, "R1");
        chk(tbw_word, 16'h0000, 16'hFFFF, "R1");
        rst_n = 1;

        // R6: result with nothing armed is ignored
        st_result_valid = 1; st_result_ok = 0; tick();
        chk(bit_word, 16'h0000, 16'h0001, "R6 unarmed");
        // R6: arm then fail
        mode_cmd(3, 1, 0); tick();
        st_result_valid = 1; st_result_ok = 0; tick();
        chk(bit_word, 16'h0001, 16'h0001, "R6 armed fail");
        // R5: timeout on bus 1
        ev_tx_timeout = 1; tx_bus = 1; tick();
        chk(bit_word, 16'h2001, 16'h3001, "R5 bus1");
        // R8 and R10: wrong T/R, set beats clear
        mode_cmd(17, 1, 0); tick();
        chk(bit_word, 16'h0008, 16'h0008, "R8 R10 set wins");
        // R9: selected shutdown illegal
        mode_cmd(20, 0, 0); tick();
        chk(bit_word, 16'h0010, 16'h0018, "R9 sel shutdown");
        // R11: inhibit, shutdown from bus 0
        mode_cmd(6, 1, 0); tick();
        mode_cmd(4, 1, 0); tick();
        chk(bit_word, 16'h0A00, 16'h0B00, "R11 inhib/shut");
        // R4: query with R7 events in the same cycle; R12 capture
        ss_illegal_n = 1; mode_cmd(19, 1, 1); ev_loop_fail = 1; tick();
        mode_cmd(2, 1, 0); tick();
        mode_cmd(18, 1, 0); ev_hs_fail = 1; tick();
        chk(bit_word, 16'h0A00, 16'h0B18, "R4 query hold");
        // R10: plain non-mode command clears 3/4
        cmd_valid = 1; tick();
        chk(bit_word, 16'h0000, 16'h0018, "R10 clear");
        // R9: subsystem illegal
        cmd_valid = 1; ss_illegal_n = 0; tick();
        // R9: reserved code with allow high
        mode_cmd(25, 0, 0); ss_allow_code = 1; tick();
        chk(bit_word, 16'h0010, 16'h0010, "R9 reserved");
        // R3: reset RT beats same-cycle events
        mode_cmd(8, 1, 0); ev_tx_timeout = 1; ev_wc_high = 1; tick();
        chk(bit_word, 16'h0000, 16'hFFFF, "R3");
        st_result_valid = 1; st_result_ok = 0; tick();

        for (int i = 0; i < 4000; i++) begin
            int c;
            int r;
            if ($urandom % 3 == 0) begin
                c = pick_code();
                r = tr_rule(c);
                cmd_valid = 1;
                cmd_mode  = ($urandom % 5) != 0;
                cmd_code  = 5'(c);
                cmd_tr    = (r >= 0) ? ((($urandom % 4) == 0) ? (r == 0) : (r == 1))
                                     : 1'($urandom % 2);
                cmd_bus   = 1'($urandom % 2);
                ss_illegal_n  = ($urandom % 10) != 0;
                ss_allow_code = 1'($urandom % 2);
            end
            ev_tx_timeout = ($urandom % 40) == 0;
            tx_bus        = 1'($urandom % 2);
            ev_loop_fail  = ($urandom % 40) == 0;
            ev_hs_fail    = ($urandom % 40) == 0;
            ev_bcast_ill  = ($urandom % 40) == 0;
            ev_wc_high    = ($urandom % 40) == 0;
            ev_wc_low     = ($urandom % 40) == 0;
            st_result_valid = ($urandom % 15) == 0;
            st_result_ok    = 1'($urandom % 2);
            tick();
            if (i == 2000) do_reset();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule